// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

A general-purpose I/O port of seven pins behind a small synchronous register interface. For each pin, software chooses whether it is an output or an input, what value it drives, which edge it watches, and whether that pin may interrupt the CPU. When a pin is an input, its output-value bit turns on a weak pullup instead of driving. Open-drain signalling needs no extra mode bit. Software holds the output bit at 0 and toggles the direction bit, so the pad drives low when set as an output and floats when set as an input.

Each input passes through a two-flop synchronizer. The synchronized level is compared with its previous sample, and an edge of the selected polarity sets a sticky per-pin flag. Flags stay set until software writes 0 to them or reset is applied. A single request line to the CPU is high while any flag whose enable bit is 1 is set. If software leaves a flag set, the request stays high and the interrupt fires again.

Registers sit at word offsets on a read/write port with address, write data, write enable and combinational read data. Reads are not registered: `bus_rdata` follows `bus_addr` in the same cycle.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every register reads 0, `pad_oe`, `pad_do` and `pad_pu` are all 0, and `irq` is 0.
- R2: For a pin whose direction bit is 1, `pad_oe` is 1 and `pad_do` equals that pin's output bit.
- R3: For a pin whose direction bit is 0, `pad_oe` and `pad_do` are 0 and `pad_pu` equals that pin's output bit. `pad_pu` and `pad_oe` are never both 1 on a pin.
- R4: With polarity bit 0, a low-to-high change on `pin_in[n]` sets flag bit n. With polarity bit 1, a high-to-low change sets it. The edge of the other direction does not set it. The flag becomes readable after the third rising clock edge following the pin change.
- R5: Flags are sticky and hardware never clears them. A write to the flag register clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R6: If an edge is detected in the same cycle in which a write clears that flag, the flag ends up set.
- R7: `irq` is 1 exactly when some pin has both its flag bit and its enable bit at 1. It stays high for as long as such a pin remains.
- R8: Bit 7 of every register reads 0, and writes to it have no effect.
- R9: Writing the polarity register while the pin level is steady never sets a flag.
- R10: Register map, with bit n of each register belonging to pin n:
  - offset 0: direction
  - offset 1: output value
  - offset 2: polarity
  - offset 3: interrupt enable
  - offset 4: flag

  Offsets 5 to 7 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 7 | Pad input levels (asynchronous) |
| pad_oe | output | 7 | Pad output enable per pin |
| pad_do | output | 7 | Pad drive value per pin |
| pad_pu | output | 7 | Weak-pullup enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a clearing write that lands in the exact cycle an edge is detected. The edge lies two synchronizer stages behind the pin, so the bench changes the pin on a falling clock edge. It then holds the write strobe for exactly the third rising edge after that change and reads the flag back afterwards. A behavioural model of the whole port tracks the synchronizer delay with plain integers. It is compared against read data, pad controls and `irq` on every clock, so a one-cycle slip in the edge or flag timing is caught even outside the directed sequences.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int unsigned OFS_DIR  = 0;
   localparam int unsigned OFS_OUT  = 1;
   localparam int unsigned OFS_POL  = 2;
   localparam int unsigned OFS_IEN  = 3;
   localparam int unsigned OFS_FLAG = 4;
   localparam int unsigned NUM_REGS = 5;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 7,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
   parameter int unsigned W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] pol,
   output logic [W-1:0] det
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   // An edge needs a level change; pol=0 keeps rising (new level 1), pol=1 keeps falling (new level 0).
   for (genvar i = 0; i < W; i++) begin : g_pin
      assign det[i] = (lvl[i] ^ prev_q[i]) & (lvl[i] ^ pol[i]);
   end

   // R9: a steady synchronized level never reports an edge, whatever the polarity
   a_r9_no_edge_on_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl == prev_q) |-> (det == '0));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
   parameter int unsigned W = 7
) (
   input  logic [W-1:0] dir,
   input  logic [W-1:0] outv,
   output logic [W-1:0] oe,
   output logic [W-1:0] dout,
   output logic [W-1:0] pu
);
   for (genvar i = 0; i < W; i++) begin : g_pad
      always_comb begin
         if (dir[i]) begin
            oe[i]   = 1'b1;
            dout[i] = outv[i];
            pu[i]   = 1'b0;
         end else begin
            oe[i]   = 1'b0;
            dout[i] = 1'b0;
            pu[i]   = outv[i];
         end
      end
   end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned NPINS       = 7,
   parameter int unsigned DW          = 8,
   parameter int unsigned AW          = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   input  logic             bus_we,
   output logic [DW-1:0]    bus_rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pad_oe,
   output logic [NPINS-1:0] pad_do,
   output logic [NPINS-1:0] pad_pu,
   output logic             irq
);
   localparam int unsigned PAD = DW - NPINS;

   if (NPINS >= DW) begin : g_bad_width
      $error("gpio_edge_port: NPINS must leave a reserved bit in DW");
   end
   if ((1 << AW) < NUM_REGS) begin : g_bad_addr
      $error("gpio_edge_port: AW too small for the register map");
   end

   logic [NPINS-1:0] dir_q, out_q, pol_q, ien_q, flag_q;
   logic [NPINS-1:0] lvl, edge_det;
   logic [NPINS-1:0] wd;
   logic             wr_dir, wr_out, wr_pol, wr_ien, wr_flag;
   logic             unused_wdata;

   assign wd           = bus_wdata[NPINS-1:0];
   assign unused_wdata = ^bus_wdata[DW-1:NPINS];

   assign wr_dir  = bus_we && (bus_addr == AW'(OFS_DIR));
   assign wr_out  = bus_we && (bus_addr == AW'(OFS_OUT));
   assign wr_pol  = bus_we && (bus_addr == AW'(OFS_POL));
   assign wr_ien  = bus_we && (bus_addr == AW'(OFS_IEN));
   assign wr_flag = bus_we && (bus_addr == AW'(OFS_FLAG));

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
   );

   gpio_edge_det #(.W(NPINS)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .pol(pol_q), .det(edge_det)
   );

   gpio_pad_ctrl #(.W(NPINS)) u_pad (
      .dir(dir_q), .outv(out_q), .oe(pad_oe), .dout(pad_do), .pu(pad_pu)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         out_q <= '0;
         pol_q <= '0;
         ien_q <= '0;
      end else begin
         if (wr_dir) dir_q <= wd;
         if (wr_out) out_q <= wd;
         if (wr_pol) pol_q <= wd;
         if (wr_ien) ien_q <= wd;
      end
   end

   // Write-zero-to-clear; a detected edge overrides a clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (wr_flag ? (flag_q & wd) : flag_q) | edge_det;
   end

   always_comb begin
      unique case (bus_addr)
         AW'(OFS_DIR):  bus_rdata = {{PAD{1'b0}}, dir_q};
         AW'(OFS_OUT):  bus_rdata = {{PAD{1'b0}}, out_q};
         AW'(OFS_POL):  bus_rdata = {{PAD{1'b0}}, pol_q};
         AW'(OFS_IEN):  bus_rdata = {{PAD{1'b0}}, ien_q};
         AW'(OFS_FLAG): bus_rdata = {{PAD{1'b0}}, flag_q};
         default:       bus_rdata = '0;
      endcase
   end

   assign irq = |(flag_q & ien_q);

   // R5: without a flag write, no flag bit ever falls
   a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

   // R4 / R6: any detected edge is visible as a set flag on the next cycle
   a_r6_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_det != '0) |=> ((flag_q & $past(edge_det)) == $past(edge_det)));

   // R7: the request cannot drop unless software touches flags or enables
   a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wr_flag && !wr_ien) |=> irq);

   // R8: the reserved top bit always reads 0
   a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DW-1] == 1'b0);

   // R3: pullup and drive are never enabled together
   a_r3_pu_excl_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_oe) == '0);
endmodule

// File: tb/sim_gpio_edge_port.sv
`timescale 1ns/1ps
module sim_gpio_edge_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_rdata;
   logic [6:0] pin_in = '0;
   logic [6:0] pad_oe, pad_do, pad_pu;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   gpio_edge_port u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu), .irq(irq)
   );

   // Behavioural model: registers as integers, synchronizer as an integer history.
   int m_reg [5];
   int m_hist [3];   // [0],[1]: synchronizer stages, [2]: previous synchronized level

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_reg[i]) m_reg[i] = 0;
         foreach (m_hist[i]) m_hist[i] = 0;
      end else begin
         int lvl, det, ad;
         lvl = m_hist[1];
         det = 0;
         for (int p = 0; p < 7; p++) begin
            int now_b, old_b, pol_b;
            now_b = (lvl >> p) & 1;
            old_b = (m_hist[2] >> p) & 1;
            pol_b = (m_reg[2] >> p) & 1;
            if (pol_b == 0 && now_b == 1 && old_b == 0) det |= (1 << p);
            if (pol_b == 1 && now_b == 0 && old_b == 1) det |= (1 << p);
         end
         ad = int'(bus_addr);
         if (bus_we && ad < 4) m_reg[ad] = int'(bus_wdata) & 8'h7f;
         if (bus_we && ad == 4) m_reg[4] = m_reg[4] & int'(bus_wdata);
         m_reg[4] = (m_reg[4] | det) & 8'h7f;
         m_hist[2] = lvl;
         m_hist[1] = m_hist[0];
         m_hist[0] = int'(pin_in);
      end
      #1;
      if (rst_n && !done) begin
         int ad, exp_rd, e_oe, e_do, e_pu;
         ad = int'(bus_addr);
         exp_rd = (ad < 5) ? m_reg[ad] : 0;
         e_oe = m_reg[0];
         e_do = m_reg[0] & m_reg[1];
         e_pu = (~m_reg[0]) & m_reg[1] & 8'h7f;
         chk(int'(bus_rdata) == exp_rd, "R10 read data", int'(bus_rdata), exp_rd);
         chk(int'(pad_oe) == e_oe && int'(pad_do) == e_do, "R2 pad drive",
             int'({pad_oe, pad_do}), (e_oe << 7) | e_do);
         chk(int'(pad_pu) == e_pu, "R3 pullup", int'(pad_pu), e_pu);
         chk(irq == ((m_reg[4] & m_reg[3]) != 0), "R7 irq", int'(irq),
             int'((m_reg[4] & m_reg[3]) != 0));
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_addr = 3'(a); bus_wdata = 8'(d); bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_exp(input int a, input int exp, input string req);
      @(negedge clk);
      bus_addr = 3'(a);
      #0.5;
      chk(int'(bus_rdata) == exp, req, int'(bus_rdata), exp);
   endtask

   task automatic set_pins(input int v);
      @(negedge clk);
      pin_in = 7'(v);
      repeat (3) @(posedge clk);
   endtask

   initial begin
      #20000;
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state at the ports
      chk(pad_oe == 0 && pad_do == 0 && pad_pu == 0, "R1 pads after reset",
          int'({pad_oe, pad_do, pad_pu}), 0);
      chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
      chk(bus_rdata == 0, "R1 reg0 after reset", int'(bus_rdata), 0);
      rst_n = 1'b1;
      for (int a = 0; a < 8; a++) rd_exp(a, 0, "R1 register after reset");

      // R2/R3: direction and output interplay, including open-drain toggling
      wr(0, 8'h55); wr(1, 8'h0f);
      @(negedge clk);
      chk(pad_oe == 7'h55 && pad_do == 7'h05, "R2 outputs drive value",
          int'({pad_oe, pad_do}), (8'h55 << 7) | 8'h05);
      chk(pad_pu == 7'h0a, "R3 inputs pullup", int'(pad_pu), 8'h0a);
      wr(1, 0); wr(0, 8'h01);
      @(negedge clk);
      chk(pad_oe[0] && !pad_do[0], "R2 open-drain low", int'({pad_oe[0], pad_do[0]}), 2);
      wr(0, 0);
      @(negedge clk);
      chk(!pad_oe[0] && !pad_pu[0], "R3 open-drain float", int'({pad_oe[0], pad_pu[0]}), 0);

      // R8: reserved bit
      wr(3, 8'hff);
      rd_exp(3, 8'h7f, "R8 reserved bit reads 0");
      wr(3, 0);
      // R10: unmapped offsets
      wr(6, 8'hff);
      rd_exp(6, 0, "R10 unmapped offset");

      // R4: rising edge on pin 2, exact timing
      @(negedge clk); pin_in = 7'h04;
      @(posedge clk); @(posedge clk);
      @(negedge clk); bus_addr = 3'd4; #0.5;
      chk(bus_rdata == 0, "R4 flag not yet set after 2 edges", int'(bus_rdata), 0);
      @(negedge clk); #0.5;
      chk(bus_rdata == 8'h04, "R4 rising edge flag", int'(bus_rdata), 8'h04);
      // R5: write 1 keeps, write 0 clears
      wr(4, 8'h7f);
      rd_exp(4, 8'h04, "R5 write one keeps flag");
      // R7: enable drives irq, stays while flag set
      wr(3, 8'h04);
      repeat (5) @(negedge clk);
      chk(irq == 1'b1, "R7 irq held by set flag", int'(irq), 1);
      wr(4, 8'h00);
      rd_exp(4, 0, "R5 write zero clears flag");
      @(negedge clk);
      chk(irq == 1'b0, "R7 irq drops after clear", int'(irq), 0);

      // R4: falling edge ignored with pol=0
      set_pins(0);
      rd_exp(4, 0, "R4 opposite edge ignored");
      // R9: polarity change on steady low pin
      wr(2, 8'h7f);
      repeat (4) @(negedge clk);
      rd_exp(4, 0, "R9 polarity write sets nothing");
      // R4: falling edge with pol=1 on pins 1 and 6
      set_pins(8'h42);
      rd_exp(4, 0, "R4 rising ignored with pol 1");
      set_pins(0);
      rd_exp(4, 8'h42, "R4 falling edge flags");
      wr(4, 0);

      // R6: clear write in the same cycle as edge detection
      wr(2, 0);
      @(negedge clk); pin_in = 7'h10;
      @(negedge clk);
      @(negedge clk);
      bus_addr = 3'd4; bus_wdata = 8'h00; bus_we = 1'b1;
      @(negedge clk); bus_we = 1'b0;
      rd_exp(4, 8'h10, "R6 set beats clear");

      // R7: enable gating
      wr(3, 0);
      @(negedge clk);
      chk(irq == 1'b0, "R7 disabled flag no irq", int'(irq), 0);
      wr(3, 8'h10);
      @(negedge clk);
      chk(irq == 1'b1, "R7 enabled flag irq", int'(irq), 1);

      repeat (4) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule